// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block is the device-side control of an asynchronous multiplexed-address DRAM. The array is kept small so that it fits on chip. The active-low strobes and the shared address pins are sampled on a fast local clock. An edge is recognised when a sample differs from the one taken at the previous clock.

A falling row strobe opens a row. The two byte column strobes are merged into one internal column strobe, which latches the column. Each byte lane starts its own read or write at the later of its lane strobe edge and the output-enable or write-enable edge. If the column strobe is already low when the row strobe falls, the cycle is a refresh. That refresh uses an internal row counter and touches no data.

Read data keeps driving after the strobes rise, in the extended-data-out style. Each refreshed row is reported on a one-cycle pulse.

Top module: `dram_cycle_decoder`

## Requirements
- R1: The row is taken from `addr_i` at the sampled fall of `ras_ni`, and the column from `addr_i` at the sampled fall of the merged column strobe. Word (row, col) is stored at index row*2^COL_BITS+col.
- R2: The merged column strobe is low while either `lcas_ni` or `ucas_ni` is low. A lane strobe that falls while the other is already low reuses the latched column and ignores the address present at that time.
- R3: Lane 0 (`dq` bits 7:0, `byte_oe_o[0]`) responds only to `lcas_ni`, and lane 1 (bits 15:8, `byte_oe_o[1]`) only to `ucas_ni`. This allows single-byte reads and writes.
- R4: A lane read starts at the later of the lane strobe fall and the `oe_ni` fall, with `we_ni` high. Data and enable appear one clock after the sample that sees the later fall.
- R5: A lane write starts at the later of the lane strobe fall and the `we_ni` fall, and takes `dq_i` at that sample. Output enables are low while `we_ni` is low.
- R6: If the column strobe is low when `ras_ni` falls, the cycle is a refresh. `cyc_kind_o` becomes 4, the address is ignored, no data is accessed and both `byte_oe_o` bits are 0.
- R7: Each refresh cycle of that kind reports the internal counter on `rfsh_row_o`, then increments it. The counter wraps from 2^ROW_BITS-1 to 0 and starts at 0 after reset.
- R8: Every other `ras_ni` fall reports the addressed row on `rfsh_row_o`, with `rfsh_valid_o` high for exactly one clock.
- R9: Read enables stay high after the strobes rise. They are cleared by `oe_ni` high, by a new merged column-strobe fall (which may itself start a new read), or by `we_ni` low.
- R10: `cyc_kind_o` encodes 0 idle, 1 row open with no access, 2 read, 3 write and 4 counter refresh. It returns to 0 the clock after `ras_ni`, `lcas_ni` and `ucas_ni` are all sampled high.
- R11: After reset, `byte_oe_o`, `cyc_kind_o`, `rfsh_valid_o` and `rfsh_row_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| lcas_ni | input | 1 | Lower byte column strobe, active low |
| ucas_ni | input | 1 | Upper byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (10) | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data to the bus |
| byte_oe_o | output | 2 | Per-lane output drive enable |
| cyc_kind_o | output | 3 | Current cycle classification |
| rfsh_valid_o | output | 1 | Pulse: a row has been refreshed |
| rfsh_row_o | output | ROW_BITS (4) | Row refreshed by the last pulse |

## Verification
The assertions rely on the bus being well behaved:
- every strobe holds for at least one sample;
- the row strobe stays high for at least one sample between cycles;
- the column strobe falls at least one sample after an opening row-strobe fall.

The stimulus changes inputs only on falling clock edges and spaces each strobe transition by at least one full clock. It also returns all strobes high before the next row-strobe fall, so every edge the design sees is isolated and the pulse and gating properties apply.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_ROW   = 3'd1,
    CYC_READ  = 3'd2,
    CYC_WRITE = 3'd3,
    CYC_CBR   = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic ras_fall;
    logic ras_rise;
    logic cas_fall;
    logic we_fall;
    logic oe_fall;
  } strobe_ev_t;
endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges
  import dram_dec_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ras_ni,
  input  logic [NUM_LANES-1:0] lane_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  output logic                 cas_n_o,
  output logic [NUM_LANES-1:0] lane_fall_o,
  output strobe_ev_t           ev_o
);
  logic ras_q, cas_q, we_q, oe_q;
  logic [NUM_LANES-1:0] lane_q;

  // merged strobe: low while any lane strobe is low
  assign cas_n_o = &lane_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      lane_q <= '1;
    end else begin
      ras_q  <= ras_ni;
      cas_q  <= cas_n_o;
      we_q   <= we_ni;
      oe_q   <= oe_ni;
      lane_q <= lane_ni;
    end
  end

  assign ev_o.ras_fall = ras_q & ~ras_ni;
  assign ev_o.ras_rise = ~ras_q & ras_ni;
  assign ev_o.cas_fall = cas_q & ~cas_n_o;
  assign ev_o.we_fall  = we_q & ~we_ni;
  assign ev_o.oe_fall  = oe_q & ~oe_ni;
  assign lane_fall_o   = lane_q & ~lane_ni;
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_dec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned ROW_BITS  = 4,
  parameter int unsigned COL_BITS  = 4,
  parameter int unsigned NUM_LANES = 2,
  localparam int unsigned IDX_W    = ROW_BITS + COL_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  strobe_ev_t           ev_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic [NUM_LANES-1:0] lane_n_i,
  input  logic [NUM_LANES-1:0] lane_fall_i,
  input  logic                 we_n_i,
  input  logic                 oe_n_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic [NUM_LANES-1:0] rd_go_o,
  output logic [NUM_LANES-1:0] wr_go_o,
  output logic                 clr_o,
  output cyc_kind_e            kind_o,
  output logic                 rfsh_valid_o,
  output logic [ROW_BITS-1:0]  rfsh_row_o
);
  localparam int unsigned ROWS  = 1 << ROW_BITS;
  localparam int unsigned LOW_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  logic [ROW_BITS-1:0] row_q, cnt_q, cnt_nxt, rfsh_row_q, addr_row;
  logic [COL_BITS-1:0] col_q, col_eff, addr_col;
  logic                row_open_q, rfsh_valid_q;
  logic                cbr_start, open_start, access_ok;
  cyc_kind_e           kind_q;

  assign addr_row = addr_i[ROW_BITS-1:0];
  assign addr_col = addr_i[COL_BITS-1:0];

  if (ADDR_W > LOW_W) begin : g_addr_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[ADDR_W-1:LOW_W];
  end

  assign cbr_start  = ev_i.ras_fall & ~cas_n_i;
  assign open_start = ev_i.ras_fall & cas_n_i;
  assign access_ok  = row_open_q & ~ras_n_i;
  // column comes from the pins only on the first lane fall
  assign col_eff    = (row_open_q && ev_i.cas_fall) ? addr_col : col_q;
  assign cnt_nxt    = (cnt_q == ROW_BITS'(ROWS - 1)) ? '0 : cnt_q + 1'b1;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_go
    assign rd_go_o[l] = access_ok & ~lane_n_i[l] & ~oe_n_i & we_n_i
                      & (lane_fall_i[l] | ev_i.oe_fall);
    assign wr_go_o[l] = access_ok & ~lane_n_i[l] & ~we_n_i
                      & (lane_fall_i[l] | ev_i.we_fall);
  end

  assign clr_o = oe_n_i | ~we_n_i | ev_i.cas_fall | cbr_start;
  assign idx_o = {row_q, col_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q        <= '0;
      col_q        <= '0;
      cnt_q        <= '0;
      rfsh_row_q   <= '0;
      rfsh_valid_q <= 1'b0;
      row_open_q   <= 1'b0;
      kind_q       <= CYC_IDLE;
    end else begin
      rfsh_valid_q <= ev_i.ras_fall;
      if (cbr_start) begin
        rfsh_row_q <= cnt_q;
        cnt_q      <= cnt_nxt;
      end else if (open_start) begin
        rfsh_row_q <= addr_row;
        row_q      <= addr_row;
      end
      if (open_start)          row_open_q <= 1'b1;
      else if (ev_i.ras_rise)  row_open_q <= 1'b0;
      if (row_open_q && ev_i.cas_fall) col_q <= addr_col;
      if (cbr_start)                kind_q <= CYC_CBR;
      else if (open_start)          kind_q <= CYC_ROW;
      else if (|wr_go_o)            kind_q <= CYC_WRITE;
      else if (|rd_go_o)            kind_q <= CYC_READ;
      else if (ras_n_i && cas_n_i)  kind_q <= CYC_IDLE;
    end
  end

  assign kind_o       = kind_q;
  assign rfsh_valid_o = rfsh_valid_q;
  assign rfsh_row_o   = rfsh_row_q;
endmodule

// File: rtl/dram_byte_lane.sv
module dram_byte_lane #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rd_go_i,
  input  logic              wr_go_i,
  input  logic              clr_i,
  input  logic [LANE_W-1:0] din_i,
  output logic [LANE_W-1:0] dout_o,
  output logic              oe_o
);
  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [LANE_W-1:0] dout_q;
  logic              oe_q;

  always_ff @(posedge clk_i) begin
    if (wr_go_i) mem_q[idx_i] <= din_i;
  end

  // a read start wins over a clear in the same sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else if (rd_go_i) begin
      dout_q <= mem_q[idx_i];
      oe_q   <= 1'b1;
    end else if (clr_i) begin
      oe_q   <= 1'b0;
    end
  end

  assign dout_o = dout_q;
  assign oe_o   = oe_q;
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned ROW_BITS = 4,
  parameter int unsigned COL_BITS = 4,
  parameter int unsigned LANE_W   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ras_ni,
  input  logic                  lcas_ni,
  input  logic                  ucas_ni,
  input  logic                  we_ni,
  input  logic                  oe_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*LANE_W-1:0]   dq_i,
  output logic [2*LANE_W-1:0]   dq_o,
  output logic [1:0]            byte_oe_o,
  output logic [2:0]            cyc_kind_o,
  output logic                  rfsh_valid_o,
  output logic [ROW_BITS-1:0]   rfsh_row_o
);
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned IDX_W     = ROW_BITS + COL_BITS;

  logic [NUM_LANES-1:0] lane_n, lane_fall, rd_go, wr_go;
  logic                 cas_n, clr;
  logic [IDX_W-1:0]     idx;
  strobe_ev_t           ev;
  cyc_kind_e            kind;

  assign lane_n = {ucas_ni, lcas_ni};

  dram_strobe_edges #(.NUM_LANES(NUM_LANES)) u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_ni     (ras_ni),
    .lane_ni    (lane_n),
    .we_ni      (we_ni),
    .oe_ni      (oe_ni),
    .cas_n_o    (cas_n),
    .lane_fall_o(lane_fall),
    .ev_o       (ev)
  );

  dram_cycle_ctrl #(
    .ADDR_W   (ADDR_W),
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .NUM_LANES(NUM_LANES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .ras_n_i     (ras_ni),
    .cas_n_i     (cas_n),
    .lane_n_i    (lane_n),
    .lane_fall_i (lane_fall),
    .we_n_i      (we_ni),
    .oe_n_i      (oe_ni),
    .addr_i      (addr_i),
    .idx_o       (idx),
    .rd_go_o     (rd_go),
    .wr_go_o     (wr_go),
    .clr_o       (clr),
    .kind_o      (kind),
    .rfsh_valid_o(rfsh_valid_o),
    .rfsh_row_o  (rfsh_row_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    dram_byte_lane #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .idx_i  (idx),
      .rd_go_i(rd_go[l]),
      .wr_go_i(wr_go[l]),
      .clr_i  (clr),
      .din_i  (dq_i[l*LANE_W +: LANE_W]),
      .dout_o (dq_o[l*LANE_W +: LANE_W]),
      .oe_o   (byte_oe_o[l])
    );
  end

  assign cyc_kind_o = kind;
endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk
  import dram_dec_pkg::*;
#(
  parameter int unsigned ROW_BITS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ras_ni,
  input logic                lcas_ni,
  input logic                ucas_ni,
  input logic                we_ni,
  input logic                oe_ni,
  input logic [1:0]          byte_oe_o,
  input logic [2:0]          cyc_kind_o,
  input logic                rfsh_valid_o,
  input logic [ROW_BITS-1:0] rfsh_row_o
);
  p_lane_lo_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_oe_o[0]) |-> (!$past(lcas_ni) && !$past(oe_ni) && $past(we_ni)));

  p_lane_hi_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_oe_o[1]) |-> (!$past(ucas_ni) && !$past(oe_ni) && $past(we_ni)));

  p_write_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> byte_oe_o == 2'b00);

  p_oe_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> byte_oe_o == 2'b00);

  p_cbr_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_kind_o == CYC_CBR |-> byte_oe_o == 2'b00);

  p_end_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && lcas_ni && ucas_ni) |=> cyc_kind_o == CYC_IDLE);

  p_rfsh_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_valid_o |-> (!$past(ras_ni) && $past(ras_ni, 2)));

  p_rfsh_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_valid_o |=> !rfsh_valid_o);

  p_rfsh_row_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_valid_o |-> $stable(rfsh_row_o));
endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.ROW_BITS(ROW_BITS)) u_chk (.*);

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
  localparam int ROW_BITS = 4;
  localparam int COL_BITS = 4;
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int COLS     = 1 << COL_BITS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  byte_oe;
  logic [2:0]  kind;
  logic        rfsh_valid;
  logic [3:0]  rfsh_row;
  logic [15:0] model [ROWS*COLS];
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  dram_cycle_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .lcas_ni(lcas_n), .ucas_ni(ucas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
    .byte_oe_o(byte_oe), .cyc_kind_o(kind), .rfsh_valid_o(rfsh_valid), .rfsh_row_o(rfsh_row)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_all();
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  function automatic logic [15:0] pat(input int r, input int c);
    return 16'((r * COLS + c) * 257) ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic wr(input int r, input int c, input logic [15:0] d, input logic [1:0] m);
    tick(); ras_n = 1'b0; addr = 10'(r);
    tick(); addr = 10'(c); we_n = 1'b0; dq_in = d; lcas_n = ~m[0]; ucas_n = ~m[1];
    tick(); idle_all();
    tick();
    model[r*COLS+c] = (model[r*COLS+c] & ~lane_mask(m)) | (d & lane_mask(m));
  endtask

  task automatic rd(input int r, input int c, input logic [1:0] m, input string req);
    logic [15:0] msk;
    msk = lane_mask(m);
    tick(); ras_n = 1'b0; addr = 10'(r);
    tick(); addr = 10'(c); oe_n = 1'b0; lcas_n = ~m[0]; ucas_n = ~m[1];
    tick();
    chk(byte_oe == m, req, 32'(byte_oe), 32'(m));
    chk((dq_out & msk) == (model[r*COLS+c] & msk), req, 32'(dq_out & msk), 32'(model[r*COLS+c] & msk));
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1;
    tick();
    chk(byte_oe == m, "R9 held after strobes rise", 32'(byte_oe), 32'(m));
    oe_n = 1'b1;
    tick();
    chk(byte_oe == 2'b00, "R9 released by OE", 32'(byte_oe), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk(byte_oe == 2'b00, "R11 byte_oe", 32'(byte_oe), 32'd0);
    chk(kind == 3'd0, "R11 kind", 32'(kind), 32'd0);
    chk(rfsh_valid == 1'b0, "R11 rfsh_valid", 32'(rfsh_valid), 32'd0);
    chk(rfsh_row == 4'd0, "R11 rfsh_row", 32'(rfsh_row), 32'd0);

    // R1 exhaustive write/read sweep
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        model[r*COLS+c] = 16'h0000;
        wr(r, c, pat(r, c), 2'b11);
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        rd(r, c, 2'b11, "R1 sweep");

    // R3 single-byte write then full and lower-only reads
    wr(3, 5, 16'hBEEF, 2'b01);
    rd(3, 5, 2'b11, "R3 byte write");
    rd(3, 5, 2'b01, "R3 lower only");
    wr(4, 6, 16'h77AA, 2'b10);
    rd(4, 6, 2'b10, "R3 upper only");
    rd(4, 6, 2'b11, "R3 upper write");

    // R2 staggered lane strobes reuse the first column
    tick(); ras_n = 1'b0; addr = 10'd2;
    tick(); addr = 10'd4; lcas_n = 1'b0; oe_n = 1'b0;
    tick();
    chk(byte_oe == 2'b01, "R3 lower lane alone", 32'(byte_oe), 32'd1);
    addr = 10'd11; ucas_n = 1'b0;
    tick();
    chk(byte_oe == 2'b11, "R2 both lanes", 32'(byte_oe), 32'd3);
    chk(dq_out == model[2*COLS+4], "R2 column from first fall", 32'(dq_out), 32'(model[2*COLS+4]));
    chk(kind == 3'd2, "R10 read kind", 32'(kind), 32'd2);
    idle_all();
    tick();

    // R4 OE falls after CAS
    tick(); ras_n = 1'b0; addr = 10'd5;
    tick(); addr = 10'd7; lcas_n = 1'b0; ucas_n = 1'b0;
    tick();
    chk(byte_oe == 2'b00, "R4 no drive before OE", 32'(byte_oe), 32'd0);
    oe_n = 1'b0;
    tick();
    chk(byte_oe == 2'b11, "R4 drive after OE", 32'(byte_oe), 32'd3);
    chk(dq_out == model[5*COLS+7], "R4 data", 32'(dq_out), 32'(model[5*COLS+7]));
    idle_all();
    tick();

    // R5 late write: WE falls after CAS, column already latched
    tick(); ras_n = 1'b0; addr = 10'd6;
    tick(); addr = 10'd1; lcas_n = 1'b0; ucas_n = 1'b0;
    tick(); we_n = 1'b0; dq_in = 16'h1234; addr = 10'd0;
    tick();
    chk(kind == 3'd3, "R10 write kind", 32'(kind), 32'd3);
    idle_all();
    tick();
    model[6*COLS+1] = 16'h1234;
    rd(6, 1, 2'b11, "R5 late write");
    rd(6, 0, 2'b11, "R5 neighbour untouched");

    // R5 write with OE low keeps outputs off
    tick(); ras_n = 1'b0; addr = 10'd7;
    tick(); addr = 10'd2; lcas_n = 1'b0; ucas_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; dq_in = 16'hC0DE;
    tick();
    chk(byte_oe == 2'b00, "R5 no drive during write", 32'(byte_oe), 32'd0);
    idle_all();
    tick();
    model[7*COLS+2] = 16'hC0DE;
    rd(7, 2, 2'b11, "R5 write with OE low");

    // R9 page read: data held past CAS rise, replaced at next CAS fall
    tick(); ras_n = 1'b0; addr = 10'd8;
    tick(); addr = 10'd3; lcas_n = 1'b0; ucas_n = 1'b0; oe_n = 1'b0;
    tick(); lcas_n = 1'b1; ucas_n = 1'b1;
    tick();
    chk(byte_oe == 2'b11, "R9 held in page", 32'(byte_oe), 32'd3);
    chk(dq_out == model[8*COLS+3], "R9 held data", 32'(dq_out), 32'(model[8*COLS+3]));
    addr = 10'd9; lcas_n = 1'b0; ucas_n = 1'b0;
    tick();
    chk(dq_out == model[8*COLS+9], "R9 next CAS data", 32'(dq_out), 32'(model[8*COLS+9]));
    idle_all();
    tick();

    // R8 / R10 RAS-only cycle
    tick(); ras_n = 1'b0; addr = 10'd9;
    tick();
    chk(rfsh_valid == 1'b1, "R8 pulse", 32'(rfsh_valid), 32'd1);
    chk(rfsh_row == 4'd9, "R8 row", 32'(rfsh_row), 32'd9);
    chk(kind == 3'd1, "R10 row-only kind", 32'(kind), 32'd1);
    tick();
    chk(rfsh_valid == 1'b0, "R8 single pulse", 32'(rfsh_valid), 32'd0);
    idle_all();
    tick();
    chk(kind == 3'd0, "R10 idle", 32'(kind), 32'd0);

    // R6 / R7 counter refresh sweep with wrap
    for (int i = 0; i <= ROWS; i++) begin
      tick(); lcas_n = 1'b0; ucas_n = 1'b0; oe_n = 1'b0; addr = 10'h3FF;
      tick(); ras_n = 1'b0;
      tick();
      chk(rfsh_valid == 1'b1, "R7 pulse", 32'(rfsh_valid), 32'd1);
      chk(rfsh_row == 4'(i % ROWS), "R7 counter row", 32'(rfsh_row), 32'(i % ROWS));
      chk(kind == 3'd4, "R6 kind", 32'(kind), 32'd4);
      chk(byte_oe == 2'b00, "R6 high-Z", 32'(byte_oe), 32'd0);
      idle_all();
      tick();
    end
    rd(15, 15, 2'b11, "R6 array untouched");
    rd(0, 0, 2'b11, "R6 array untouched");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule